// File: doc/BRIEF.md
# Priority Interrupt Controller with Nesting

This block collects up to 64 peripheral interrupt sources and decides which one, if any, is offered to the processor. Each source holds a pending flag, an enable bit, a 3-bit priority and an edge-polarity bit. A flag is set by the selected edge on the source's external line, or it is written directly by software to force or withdraw a request. Of all pending and enabled sources with a non-zero priority, the highest priority wins. Among equal priorities the lowest source index wins. The winner is offered on `irq_req` with vector number `VEC_BASE + index`, but only when four gates allow it: the global enable, the running priority level, the nesting mode, and the critical-section threshold.

When the processor acknowledges an offered request, the running level is pushed onto a small stack and replaced by the accepted priority. A return pulse restores the saved level. A separate critical-section threshold can be loaded in a single cycle, and its previous value is presented so that software can save and restore it around nested critical sections. Independently of acceptance, a wake output tells a sleeping or idle processor that work is pending. The processor then either vectors or simply resumes execution.

Software access is a plain write strobe with a kind code, a source index and a 3-bit data value. The kind codes are: 0 flag, 1 enable, 2 priority, 3 polarity, 4 control, 5 running level. Kinds 6 and 7 are ignored. For kinds 0, 1 and 3 only data bit 0 is used.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Every source enable resets to 0. A source whose enable is 0 never causes `irq_req`, even with its flag set. Kind 1 writes data bit 0 into the enable of source `reg_wr_idx`.
- R2: The global enable resets to 1 and is data bit 0 of a kind-4 write. While it is 0, `irq_req` stays low and peripheral sources do not wake the processor, but `trap_req` together with `cpu_sleep` still drives `wake` high in the same cycle.
- R3: The running level `run_level` resets to 0. `irq_req` is high only when the winning priority is strictly greater than `run_level`. A level of 7 therefore blocks every source.
- R4: A source with priority 0 (set by a kind-2 write of data 0) never raises `irq_req` and never raises `wake`.
- R5: The nesting-disable bit resets to 0 and is data bit 1 of a kind-4 write. While it is 1 and a handler is active, `irq_req` stays low and kind-5 level writes leave `run_level` unchanged.
- R6: A `crit_load` cycle takes `crit_value` as the threshold in that same cycle. `crit_thresh` shows the active threshold. Sources with priority at or below the threshold do not raise `irq_req`. During the load cycle `crit_prev` shows the threshold held before the load, and from the next cycle on it shows the loaded value.
- R7: `wake` is high exactly when `cpu_sleep` is high and either `trap_req` is high or an enabled, pending, non-zero-priority source exists under the global enable. `wake` is independent of `run_level`, of the threshold and of nesting.
- R8: The winner is the highest priority among pending, enabled sources. On a tie the lowest index wins. `irq_vector` equals `VEC_BASE` (default 8) plus the winner's index, and `irq_prio` equals its priority.
- R9: `cpu_ack` while `irq_req` is high pushes `run_level` and loads it with `irq_prio` on the next cycle, and `handler_active` rises. The acknowledged flag is not cleared by hardware. A higher-priority request then preempts the handler when nesting is enabled.
- R10: `cpu_ret` restores the most recently pushed level and pops it. `handler_active` falls when the stack empties. A return with an empty stack, or in the same cycle as an accepted acknowledge, has no effect.
- R11: An external line sets its flag on a rising edge when its polarity is 0 and on a falling edge when its polarity is 1. A kind-0 write sets or clears a flag. An edge in the same cycle as a software clear leaves the flag set.
- R12: The level stack holds `STACK_DEPTH` (default 8) entries. While it is full, `irq_req` stays low, so no acknowledge can overflow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | N_SRC | External interrupt lines, one per source |
| reg_wr_en | input | 1 | Software write strobe |
| reg_wr_kind | input | 3 | Write kind code (0 flag, 1 enable, 2 priority, 3 polarity, 4 control, 5 level) |
| reg_wr_idx | input | log2(N_SRC) | Source index for kinds 0 to 3 |
| reg_wr_data | input | 3 | Write data |
| crit_load | input | 1 | Load the critical-section threshold this cycle |
| crit_value | input | 3 | New critical-section threshold |
| cpu_ack | input | 1 | Processor acknowledges the offered request |
| cpu_ret | input | 1 | Processor returns from a handler |
| cpu_sleep | input | 1 | Processor is in sleep or idle |
| trap_req | input | 1 | Trap request, used only for wake-up |
| irq_req | output | 1 | Request offered to the processor |
| irq_vector | output | VEC_W | Vector number of the winning source |
| irq_prio | output | 3 | Priority of the winning source |
| run_level | output | 3 | Running priority level |
| handler_active | output | 1 | At least one handler level is stacked |
| wake | output | 1 | Wake-up indication |
| crit_thresh | output | 3 | Active critical-section threshold |
| crit_prev | output | 3 | Threshold held before the current cycle |

## Verification
The two functions that can land in the same cycle are the edge detector setting a flag and a software write clearing that same flag. The bench provokes this by toggling a line in the polarity's active direction in exactly the cycle of a kind-0 clear. It judges the result by the request and vector offered in the following cycle, which must show the flag survived. A similar overlap, between an acknowledge and a return pulse, is provoked in a long random phase in which acknowledges, returns, threshold loads and writes are mixed freely. There a behavioural reference model compares the request, vector, level, activity, wake and threshold outputs on every clock.

// File: rtl/pic_pkg.sv
// Shared types and write-kind codes for the priority interrupt controller.
// Assumes 3-bit priorities; all modules of the controller import this package.
package pic_pkg;
    localparam int PRIO_W = 3;

    typedef logic [PRIO_W-1:0] prio_t;

    // Software write kinds; codes 6 and 7 are ignored by every unit.
    typedef enum logic [2:0] {
        WK_FLAG     = 3'd0,
        WK_ENABLE   = 3'd1,
        WK_PRIO     = 3'd2,
        WK_POLARITY = 3'd3,
        WK_CONTROL  = 3'd4,
        WK_LEVEL    = 3'd5
    } wr_kind_e;
endpackage

// File: rtl/pic_src_bank.sv
// Per-source state: pending flag, enable, priority, edge polarity and line history.
// Assumes lines are already synchronous to clk. An edge on the line wins over a
// software clear of the same flag in the same cycle.
module pic_src_bank
    import pic_pkg::*;
#(
    parameter  int N_SRC = 64,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              line_i,
    input  logic                          wr_en_i,
    input  logic [2:0]                    wr_kind_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  logic [2:0]                    wr_data_i,
    output logic [N_SRC-1:0]              flag_o,
    output logic [N_SRC-1:0]              en_o,
    output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic  hit;
        logic  edge_seen;
        logic  flag_q;
        logic  en_q;
        logic  pol_q;
        logic  prev_q;
        prio_t prio_q;

        assign hit       = wr_en_i && (wr_idx_i == IDX_W'(g));
        assign edge_seen = pol_q ? (prev_q & ~line_i[g]) : (~prev_q & line_i[g]);

        // Source registers: edge history, configuration and pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                en_q   <= 1'b0;
                pol_q  <= 1'b0;
                prev_q <= 1'b0;
                prio_q <= '0;
            end else begin
                prev_q <= line_i[g];
                if (hit && wr_kind_i == WK_ENABLE)   en_q   <= wr_data_i[0];
                if (hit && wr_kind_i == WK_POLARITY) pol_q  <= wr_data_i[0];
                if (hit && wr_kind_i == WK_PRIO)     prio_q <= wr_data_i;
                if (edge_seen)                       flag_q <= 1'b1;
                else if (hit && wr_kind_i == WK_FLAG) flag_q <= wr_data_i[0];
            end
        end

        assign flag_o[g] = flag_q;
        assign en_o[g]   = en_q;
        assign prio_o[g] = prio_q;
    end
endmodule

// File: rtl/pic_arbiter.sv
// Selects the highest-priority pending and enabled source; ties go to the lowest
// index. Priority 0 counts as disabled. Purely combinational.
module pic_arbiter
    import pic_pkg::*;
#(
    parameter  int N_SRC = 64,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]              flag_i,
    input  logic [N_SRC-1:0]              en_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
    output logic                          found_o,
    output logic [IDX_W-1:0]              idx_o,
    output prio_t                         prio_o
);
    // Downward scan with >= so that the lowest index survives a tie.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (flag_i[i] && en_i[i] && (prio_i[i] != '0) && (prio_i[i] >= prio_o)) begin
                found_o = 1'b1;
                prio_o  = prio_i[i];
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_level_unit.sv
// Running level with its save stack, global and nesting controls, and the
// critical-section threshold. Assumes take_i is only raised when the stack
// has room. Acknowledge beats return, and return beats a software level write.
module pic_level_unit
    import pic_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  prio_t            take_prio_i,
    input  logic             ret_i,
    input  logic             lvl_wr_i,
    input  prio_t            lvl_data_i,
    input  logic             ctrl_wr_i,
    input  logic [1:0]       ctrl_data_i,
    input  logic             crit_load_i,
    input  prio_t            crit_val_i,
    output prio_t            level_o,
    output logic [CNT_W-1:0] depth_o,
    output logic             full_o,
    output logic             gie_o,
    output logic             nest_dis_o,
    output prio_t            thresh_o,
    output prio_t            eff_thresh_o
);
    prio_t            level_q;
    logic [CNT_W-1:0] depth_q;
    logic [CNT_W-1:0] below;
    prio_t            stack_q [DEPTH];
    logic             gie_q;
    logic             nest_dis_q;
    prio_t            thresh_q;

    assign below = depth_q - CNT_W'(1);

    // Running level and stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            depth_q <= '0;
        end else if (take_i) begin
            level_q <= take_prio_i;
            depth_q <= depth_q + CNT_W'(1);
        end else if (ret_i && depth_q != '0) begin
            level_q <= stack_q[below[PTR_W-1:0]];
            depth_q <= below;
        end else if (lvl_wr_i && !nest_dis_q) begin
            level_q <= lvl_data_i;
        end
    end

    // Stack storage: the level being replaced is written at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stack_q[i] <= '0;
        end else if (take_i) begin
            stack_q[depth_q[PTR_W-1:0]] <= level_q;
        end
    end

    // Global enable and nesting-disable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q      <= 1'b1;
            nest_dis_q <= 1'b0;
        end else if (ctrl_wr_i) begin
            gie_q      <= ctrl_data_i[0];
            nest_dis_q <= ctrl_data_i[1];
        end
    end

    // Critical-section threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)           thresh_q <= '0;
        else if (crit_load_i) thresh_q <= crit_val_i;
    end

    assign level_o      = level_q;
    assign depth_o      = depth_q;
    assign full_o       = (depth_q == CNT_W'(DEPTH));
    assign gie_o        = gie_q;
    assign nest_dis_o   = nest_dis_q;
    assign thresh_o     = thresh_q;
    assign eff_thresh_o = crit_load_i ? crit_val_i : thresh_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the priority interrupt controller. Combines the source bank, the
// arbiter and the level unit, and gates the offered request. Assumes the
// processor raises cpu_ack only while irq_req is high; other acks are ignored.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter  int N_SRC       = 64,
    parameter  int STACK_DEPTH = 8,
    parameter  int VEC_BASE    = 8,
    parameter  int VEC_W       = 8,
    localparam int IDX_W       = $clog2(N_SRC),
    localparam int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_lines,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_wr_kind,
    input  logic [IDX_W-1:0] reg_wr_idx,
    input  logic [2:0]       reg_wr_data,
    input  logic             crit_load,
    input  logic [2:0]       crit_value,
    input  logic             cpu_ack,
    input  logic             cpu_ret,
    input  logic             cpu_sleep,
    input  logic             trap_req,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic [2:0]       irq_prio,
    output logic [2:0]       run_level,
    output logic             handler_active,
    output logic             wake,
    output logic [2:0]       crit_thresh,
    output logic [2:0]       crit_prev
);
    logic [N_SRC-1:0]             src_flag;
    logic [N_SRC-1:0]             src_en;
    logic [N_SRC-1:0][PRIO_W-1:0] src_prio;
    logic                         cand_found;
    logic [IDX_W-1:0]             cand_idx;
    prio_t                        cand_prio;
    prio_t                        level;
    prio_t                        eff_thresh;
    prio_t                        thresh;
    logic [CNT_W-1:0]             depth;
    logic                         stack_full;
    logic                         gie;
    logic                         nest_dis;
    logic                         take;
    logic                         lvl_wr;
    logic                         ctrl_wr;

    pic_src_bank #(.N_SRC(N_SRC)) i_src_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (irq_lines),
        .wr_en_i   (reg_wr_en),
        .wr_kind_i (reg_wr_kind),
        .wr_idx_i  (reg_wr_idx),
        .wr_data_i (reg_wr_data),
        .flag_o    (src_flag),
        .en_o      (src_en),
        .prio_o    (src_prio)
    );

    pic_arbiter #(.N_SRC(N_SRC)) i_arbiter (
        .flag_i  (src_flag),
        .en_i    (src_en),
        .prio_i  (src_prio),
        .found_o (cand_found),
        .idx_o   (cand_idx),
        .prio_o  (cand_prio)
    );

    assign lvl_wr  = reg_wr_en && (reg_wr_kind == WK_LEVEL);
    assign ctrl_wr = reg_wr_en && (reg_wr_kind == WK_CONTROL);
    assign take    = cpu_ack && irq_req;

    pic_level_unit #(.DEPTH(STACK_DEPTH)) i_level_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take),
        .take_prio_i  (cand_prio),
        .ret_i        (cpu_ret),
        .lvl_wr_i     (lvl_wr),
        .lvl_data_i   (reg_wr_data),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_data_i  (reg_wr_data[1:0]),
        .crit_load_i  (crit_load),
        .crit_val_i   (crit_value),
        .level_o      (level),
        .depth_o      (depth),
        .full_o       (stack_full),
        .gie_o        (gie),
        .nest_dis_o   (nest_dis),
        .thresh_o     (thresh),
        .eff_thresh_o (eff_thresh)
    );

    // Acceptance gate: global enable, level, threshold, nesting and stack room.
    always_comb begin
        irq_req = gie && cand_found
               && (cand_prio > level)
               && (cand_prio > eff_thresh)
               && !(nest_dis && depth != '0)
               && !stack_full;
    end

    assign irq_vector     = VEC_W'(VEC_BASE) + VEC_W'(cand_idx);
    assign irq_prio       = cand_prio;
    assign run_level      = level;
    assign handler_active = (depth != '0);
    assign wake           = cpu_sleep && (trap_req || (gie && cand_found));
    assign crit_thresh    = eff_thresh;
    assign crit_prev      = thresh;
endmodule

// File: rtl/pic_checker.sv
// Property checker for prio_irq_ctrl, attached by bind. Observes ports and the
// control state shared between the level unit and the acceptance gate.
module pic_checker #(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic [2:0]       irq_prio,
    input logic [2:0]       run_level,
    input logic             handler_active,
    input logic             wake,
    input logic             cpu_ack,
    input logic             cpu_ret,
    input logic             cpu_sleep,
    input logic             trap_req,
    input logic [2:0]       crit_thresh,
    input logic [2:0]       crit_prev,
    input logic             crit_load,
    input logic [2:0]       crit_value,
    input logic             gie,
    input logic             nest_dis,
    input logic [CNT_W-1:0] depth
);
    assert_gie_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_req);

    assert_trap_wakes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sleep && trap_req) |-> wake);

    assert_req_above_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio > run_level));

    assert_zero_prio_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio != 3'd0));

    assert_nest_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_dis && handler_active) |-> !irq_req);

    assert_crit_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio > crit_thresh));

    assert_crit_saved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crit_load |=> (crit_prev == $past(crit_value)));

    assert_wake_needs_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sleep |-> !wake);

    assert_ack_raises_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && irq_req) |=> ((run_level == $past(irq_prio)) && handler_active));

    assert_ret_pops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ret && !(cpu_ack && irq_req) && depth != '0) |=> (depth == $past(depth) - CNT_W'(1)));

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        32'(depth) <= DEPTH);
endmodule

bind prio_irq_ctrl pic_checker #(.DEPTH(STACK_DEPTH)) i_pic_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq_req        (irq_req),
    .irq_prio       (irq_prio),
    .run_level      (run_level),
    .handler_active (handler_active),
    .wake           (wake),
    .cpu_ack        (cpu_ack),
    .cpu_ret        (cpu_ret),
    .cpu_sleep      (cpu_sleep),
    .trap_req       (trap_req),
    .crit_thresh    (crit_thresh),
    .crit_prev      (crit_prev),
    .crit_load      (crit_load),
    .crit_value     (crit_value),
    .gie            (gie),
    .nest_dis       (nest_dis),
    .depth          (depth)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/100ps
// Bench for prio_irq_ctrl: a behavioural reference model is compared on every
// clock, with directed scenarios per requirement and a random phase.
module test_prio_irq_ctrl;
    localparam int N     = 64;
    localparam int DEPTH = 8;
    localparam int VBASE = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] lines = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_kind = '0;
    logic [5:0]   wr_idx = '0;
    logic [2:0]   wr_data = '0;
    logic         crit_load = 1'b0;
    logic [2:0]   crit_value = '0;
    logic         ack = 1'b0;
    logic         ret = 1'b0;
    logic         sleep = 1'b0;
    logic         trap = 1'b0;

    logic         irq_req;
    logic [7:0]   irq_vector;
    logic [2:0]   irq_prio;
    logic [2:0]   run_level;
    logic         handler_active;
    logic         wake;
    logic [2:0]   crit_thresh;
    logic [2:0]   crit_prev;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    bit m_flag [N];
    bit m_en   [N];
    bit m_pol  [N];
    bit m_prev [N];
    int m_prio [N];
    int m_level;
    int m_stack [$];
    bit m_gie;
    bit m_nd;
    int m_th;

    always #2 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_lines      (lines),
        .reg_wr_en      (wr_en),
        .reg_wr_kind    (wr_kind),
        .reg_wr_idx     (wr_idx),
        .reg_wr_data    (wr_data),
        .crit_load      (crit_load),
        .crit_value     (crit_value),
        .cpu_ack        (ack),
        .cpu_ret        (ret),
        .cpu_sleep      (sleep),
        .trap_req       (trap),
        .irq_req        (irq_req),
        .irq_vector     (irq_vector),
        .irq_prio       (irq_prio),
        .run_level      (run_level),
        .handler_active (handler_active),
        .wake           (wake),
        .crit_thresh    (crit_thresh),
        .crit_prev      (crit_prev)
    );

    task automatic expect_eq(input int actual, input int expected, input string tag);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_flag[i] = 0; m_en[i] = 0; m_pol[i] = 0; m_prev[i] = 0; m_prio[i] = 0;
        end
        m_level = 0;
        m_stack.delete();
        m_gie = 1;
        m_nd  = 0;
        m_th  = 0;
    endfunction

    function automatic void model_eval(output bit req, output int vec, output int bp,
                                       output bit wk, output int eff);
        bit found = 0;
        int bi = 0;
        bp = 0;
        for (int i = 0; i < N; i++) begin
            if (m_flag[i] && m_en[i] && m_prio[i] > bp) begin
                found = 1; bp = m_prio[i]; bi = i;
            end
        end
        eff = crit_load ? int'(crit_value) : m_th;
        req = m_gie && found && bp > m_level && bp > eff
              && !(m_nd && m_stack.size() != 0) && m_stack.size() < DEPTH;
        vec = VBASE + bi;
        wk  = sleep && (trap || (m_gie && found));
    endfunction

    function automatic void model_update(input bit req, input int bp);
        if (!rst_n) begin
            model_reset();
            return;
        end
        for (int i = 0; i < N; i++) begin
            bit e   = m_pol[i] ? (m_prev[i] && !lines[i]) : (!m_prev[i] && lines[i]);
            bit sel = wr_en && (int'(wr_idx) == i);
            if (e) m_flag[i] = 1;
            else if (sel && wr_kind == 3'd0) m_flag[i] = wr_data[0];
            if (sel && wr_kind == 3'd1) m_en[i]   = wr_data[0];
            if (sel && wr_kind == 3'd2) m_prio[i] = int'(wr_data);
            if (sel && wr_kind == 3'd3) m_pol[i]  = wr_data[0];
            m_prev[i] = lines[i];
        end
        if (ack && req) begin
            m_stack.push_back(m_level);
            m_level = bp;
        end else if (ret && m_stack.size() > 0) begin
            m_level = m_stack.pop_back();
        end else if (wr_en && wr_kind == 3'd5 && !m_nd) begin
            m_level = int'(wr_data);
        end
        if (wr_en && wr_kind == 3'd4) begin
            m_gie = wr_data[0];
            m_nd  = wr_data[1];
        end
        if (crit_load) m_th = int'(crit_value);
    endfunction

    // One clock: compare outputs mid-cycle, then advance the model at the edge.
    task automatic tick();
        bit req, wk;
        int vec, bp, eff;
        #0.5;
        model_eval(req, vec, bp, wk, eff);
        if (rst_n) begin
            expect_eq(irq_req, req, "R3 request gate");
            if (req) begin
                expect_eq(irq_vector, vec, "R8 vector");
                expect_eq(irq_prio, bp, "R8 priority");
            end
            expect_eq(run_level, m_level, "R9 running level");
            expect_eq(handler_active, m_stack.size() != 0, "R10 handler active");
            expect_eq(wake, wk, "R7 wake");
            expect_eq(crit_thresh, eff, "R6 threshold");
            expect_eq(crit_prev, m_th, "R6 previous threshold");
        end
        @(posedge clk);
        model_update(req, bp);
        @(negedge clk);
    endtask

    task automatic settle();
        #0.5;
    endtask

    task automatic wr(input int kind, input int idx, input int data);
        wr_en = 1'b1; wr_kind = 3'(kind); wr_idx = 6'(idx); wr_data = 3'(data);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_ret();
        ret = 1'b1; tick(); ret = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) tick();
        rst_n = 1'b1;
        settle();
        expect_eq(irq_req, 0, "R1 reset no request");
        expect_eq(run_level, 0, "R3 reset level");
        expect_eq(handler_active, 0, "R10 reset idle");
        expect_eq(crit_thresh, 0, "R6 reset threshold");

        // R1: pending but disabled source stays silent.
        wr(2, 5, 3);
        wr(0, 5, 1);
        settle();
        expect_eq(irq_req, 0, "R1 disabled source");
        wr(1, 5, 1);
        settle();
        expect_eq(irq_req, 1, "R1 enabled source");
        expect_eq(irq_vector, 13, "R8 vector of source 5");

        // R8: tie at priority 3 goes to the lower index.
        wr(2, 2, 3); wr(1, 2, 1); wr(0, 2, 1);
        settle();
        expect_eq(irq_vector, 10, "R8 tie lower index");
        wr(2, 40, 6); wr(1, 40, 1); wr(0, 40, 1);
        settle();
        expect_eq(irq_vector, 48, "R8 highest priority");
        expect_eq(irq_prio, 6, "R8 highest priority value");

        // R9: acknowledge raises the level and nests a higher request.
        do_ack();
        settle();
        expect_eq(run_level, 6, "R9 level after ack");
        expect_eq(handler_active, 1, "R9 handler active");
        expect_eq(irq_req, 0, "R3 equal priority blocked");
        wr(2, 50, 7); wr(1, 50, 1); wr(0, 50, 1);
        settle();
        expect_eq(irq_req, 1, "R9 preempt offered");
        do_ack();
        settle();
        expect_eq(run_level, 7, "R9 nested level");

        // R10: returns unwind, an empty return is ignored.
        do_ret();
        settle();
        expect_eq(run_level, 6, "R10 first pop");
        do_ret();
        settle();
        expect_eq(run_level, 0, "R10 second pop");
        expect_eq(handler_active, 0, "R10 stack empty");
        do_ret();
        settle();
        expect_eq(run_level, 0, "R10 empty return ignored");
        expect_eq(irq_vector, 58, "R9 flag kept after ack");

        wr(0, 50, 0); wr(0, 40, 0);

        // R6: threshold applies in the load cycle, previous value follows.
        crit_load = 1'b1; crit_value = 3'd3;
        settle();
        expect_eq(irq_req, 0, "R6 same-cycle block");
        expect_eq(crit_prev, 0, "R6 previous during load");
        tick();
        crit_load = 1'b0;
        settle();
        expect_eq(crit_prev, 3, "R6 saved after load");
        expect_eq(irq_req, 0, "R6 still blocked");
        crit_load = 1'b1; crit_value = 3'd2;
        settle();
        expect_eq(irq_req, 1, "R6 lowered threshold");
        expect_eq(crit_prev, 3, "R6 previous for restore");
        tick();
        crit_value = 3'd0;
        tick();
        crit_load = 1'b0;

        // R2: global disable masks requests; traps still wake.
        wr(4, 0, 0);
        sleep = 1'b1;
        settle();
        expect_eq(irq_req, 0, "R2 global disable");
        expect_eq(wake, 0, "R2 peripheral wake masked");
        trap = 1'b1;
        tick();
        settle();
        expect_eq(wake, 1, "R2 trap wakes");
        trap = 1'b0;
        wr(4, 0, 1);
        wr(5, 0, 7);
        settle();
        expect_eq(run_level, 7, "R3 level write");
        expect_eq(irq_req, 0, "R3 level seven blocks");
        expect_eq(wake, 1, "R7 wake ignores level");
        wr(5, 0, 0);
        sleep = 1'b0;
        tick();

        // R4: priority zero neither requests nor wakes.
        wr(0, 2, 0); wr(0, 5, 0);
        wr(1, 9, 1); wr(0, 9, 1);
        sleep = 1'b1;
        settle();
        expect_eq(irq_req, 0, "R4 zero priority request");
        expect_eq(wake, 0, "R4 zero priority wake");
        tick();
        sleep = 1'b0;
        wr(1, 9, 0);

        // R5: nesting disabled blocks preemption and freezes the level.
        wr(4, 0, 3);
        wr(2, 20, 2); wr(1, 20, 1); wr(0, 20, 1);
        do_ack();
        wr(2, 21, 5); wr(1, 21, 1); wr(0, 21, 1);
        settle();
        expect_eq(irq_req, 0, "R5 no nesting");
        wr(5, 0, 0);
        settle();
        expect_eq(run_level, 2, "R5 level read-only");
        do_ret();
        settle();
        expect_eq(irq_req, 1, "R5 after return");
        expect_eq(irq_vector, 29, "R5 vector after return");
        wr(0, 20, 0); wr(0, 21, 0);
        wr(4, 0, 1);

        // R11: edge polarity and edge versus software clear.
        wr(2, 60, 1); wr(1, 60, 1);
        wr(2, 61, 1); wr(1, 61, 1); wr(3, 61, 1);
        lines[60] = 1'b1;
        tick();
        settle();
        expect_eq(irq_vector, 68, "R11 rising edge sets");
        wr(0, 60, 0);
        lines[60] = 1'b0;
        tick();
        settle();
        expect_eq(irq_req, 0, "R11 falling ignored on rising line");
        lines[61] = 1'b1;
        tick();
        settle();
        expect_eq(irq_req, 0, "R11 rising ignored on falling line");
        lines[61] = 1'b0;
        tick();
        settle();
        expect_eq(irq_vector, 69, "R11 falling edge sets");
        wr(0, 61, 0);
        lines[60] = 1'b1;
        wr(0, 60, 0);
        settle();
        expect_eq(irq_req, 1, "R11 edge beats clear");
        expect_eq(irq_vector, 68, "R11 edge beats clear vector");
        wr(0, 60, 0);
        lines[60] = 1'b0;
        tick();
        wr(1, 60, 0); wr(1, 61, 0);

        // R12: fill the stack by re-lowering the level after each ack.
        wr(2, 30, 1); wr(1, 30, 1); wr(0, 30, 1);
        for (int k = 0; k < DEPTH; k++) begin
            settle();
            expect_eq(irq_req, 1, "R12 room left");
            do_ack();
            wr(5, 0, 0);
        end
        settle();
        expect_eq(irq_req, 0, "R12 stack full blocks");
        do_ret();
        settle();
        expect_eq(irq_req, 1, "R12 room after pop");
        for (int k = 0; k < DEPTH; k++) do_ret();
        wr(0, 30, 0);

        // Random phase, compared against the model every cycle.
        for (int c = 0; c < 3000; c++) begin
            lines      = {$urandom, $urandom};
            wr_en      = ($urandom % 3) == 0;
            wr_kind    = 3'($urandom % 8);
            wr_idx     = ($urandom % 2) ? 6'($urandom % 8) : 6'($urandom % 64);
            wr_data    = 3'($urandom);
            ack        = ($urandom % 3) == 0;
            ret        = ($urandom % 5) == 0;
            crit_load  = ($urandom % 16) == 0;
            crit_value = 3'($urandom % 4);
            sleep      = ($urandom % 2) == 0;
            trap       = ($urandom % 8) == 0;
            tick();
        end
        wr_en = 1'b0; ack = 1'b0; ret = 1'b0; crit_load = 1'b0;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule